// File: doc/BRIEF.md
# Boundary-Chunked Write Forwarding Buffer

This block sits between a fast write source that streams memory-write bursts and a slower destination that takes plain memory-write bursts. Incoming beats carry 32 bits of data and four byte enables. They are collected into 128-byte staging chunks that are aligned to 128-byte address boundaries. A chunk is handed to the output side when the stream fills its top beat, which is the moment the burst reaches a 128-byte boundary, or when the beat marked last is accepted. Two chunk stores work in ping-pong, so one can fill while the other drains.

Each output burst starts at the aligned base address of its chunk. It runs from beat 0 up to the highest beat written in that chunk. Beats that were never written come out with all byte enables low. The plain write command and the block write command both leave as the plain write command.

Both streams use valid/ready. The source holds `in_valid` and its payload until `in_ready` is seen high at a clock edge. `in_ready` depends only on internal state, never on `in_valid`. The output holds `out_valid` and every output field stable until `out_ready` is high at a clock edge. A beat is consumed only on that handshake.

Top module: `wr_chunk_fwd`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_addr` is sampled only on a beat with `in_first` high. Each later beat of the same burst takes the previous beat address plus 4, whatever `in_addr` carries.
- R3: A chunk whose beat index 31 (address bits [6:2] all ones) is written is offered as a 32-beat burst. Its `out_addr` is the address with bits [6:0] cleared, and `out_last` is high on the 32nd beat.
- R4: Accepting an `in_last` beat hands over its chunk at once. The burst covers beats 0 up to the highest index written, with `out_last` on that beat.
- R5: A written beat leaves with the data and byte enables it arrived with. A beat of the chunk that was never written leaves with `out_be` = 4'b0000.
- R6: The command is captured on the `in_first` beat. Plain write (4'b0111) and block write (4'b1111) are both issued as `out_cmd` = 4'b0111.
- R7: Input is taken while the other chunk drains. When both chunks are waiting to drain, `in_ready` is 0 and no beat is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_data`, `out_be` and `out_last` hold their values.
- R9: A burst that spans several 128-byte regions leaves as one output burst per region, in ascending address order, each with its own base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat may be taken |
| in_first | input | 1 | First beat of a burst |
| in_last | input | 1 | Final beat of a burst |
| in_cmd | input | 4 | Write command, sampled on the first beat |
| in_addr | input | 32 | Byte address, sampled on the first beat |
| in_data | input | 32 | Write data |
| in_be | input | 4 | Byte enables of the beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Destination takes the beat |
| out_addr | output | 32 | Aligned base address of the chunk burst |
| out_cmd | output | 4 | Outgoing command |
| out_data | output | 32 | Beat data |
| out_be | output | 4 | Beat byte enables, 0 for unwritten beats |
| out_last | output | 1 | Final beat of the chunk burst |

## Verification
An aligned 32-beat burst exercises the boundary trigger on its own. A short burst that starts mid-chunk separates the end-of-burst trigger from the boundary trigger and exposes the zeroed leading byte enables. A burst that starts four beats below a boundary and runs for 40 beats yields three output bursts, which confirms splitting and ordering. A burst that ends exactly at index 31 shows that hitting both triggers at once yields a single hand-over. Holding `out_ready` low while two full chunks arrive confirms the stall, and random output back-pressure on a long burst checks that held beats stay stable and that filling overlaps with draining.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
  localparam logic [3:0] CMD_MWR     = 4'b0111;
  localparam logic [3:0] CMD_MWR_BLK = 4'b1111;

  // both memory-write forms leave as the plain form
  function automatic logic [3:0] wfb_xlate(input logic [3:0] c);
    return (c == CMD_MWR_BLK) ? CMD_MWR : c;
  endfunction
endpackage

// File: rtl/wfb_fill_ctrl.sv
module wfb_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 7,
  parameter int BSH    = 2,
  parameter int IDX_W  = 5,
  parameter int NB     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic [3:0]              in_cmd,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [NB-1:0]           full,
  output logic                    in_ready,
  output logic                    wr_en,
  output logic                    wr_bank,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [ADDR_W-OFS_W-1:0] wr_base,
  output logic [3:0]              wr_cmd,
  output logic                    commit
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << BSH);

  logic [ADDR_W-1:0] nxt_addr, beat_addr;
  logic [3:0]        burst_cmd;
  logic              fill_bank;

  assign beat_addr = in_first ? in_addr : nxt_addr;
  assign wr_idx    = beat_addr[OFS_W-1:BSH];
  assign wr_base   = beat_addr[ADDR_W-1:OFS_W];
  assign wr_cmd    = in_first ? in_cmd : burst_cmd;
  assign in_ready  = !full[fill_bank];
  assign wr_en     = in_valid && in_ready;
  assign wr_bank   = fill_bank;
  // top slot reached (boundary) or burst over: hand the chunk over
  assign commit    = wr_en && (in_last || (&wr_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_addr  <= '0;
      burst_cmd <= '0;
      fill_bank <= 1'b0;
    end else if (wr_en) begin
      nxt_addr  <= beat_addr + STEP;
      burst_cmd <= wr_cmd;
      if (commit) fill_bank <= ~fill_bank;
    end
  end

  a_r7_stall_when_both: assert property (@(posedge clk) disable iff (!rst_n)
    (&full) |-> !in_ready);
endmodule

// File: rtl/wfb_chunk_bank.sv
module wfb_chunk_bank #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int OFS_W  = 7,
  parameter int BEATS  = 32,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [BE_W-1:0]         wr_be,
  input  logic [ADDR_W-OFS_W-1:0] wr_base,
  input  logic [3:0]              wr_cmd,
  input  logic                    set_full,
  input  logic                    release_i,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    full,
  output logic [ADDR_W-OFS_W-1:0] base,
  output logic [IDX_W-1:0]        hi_idx,
  output logic [3:0]              cmd,
  output logic [DATA_W-1:0]       rd_data,
  output logic [BE_W-1:0]         rd_be
);
  logic [DATA_W-1:0] dmem [BEATS];
  logic [BE_W-1:0]   bmem [BEATS];

  always_ff @(posedge clk) begin
    if (wr_en) dmem[wr_idx] <= wr_data;
  end

  // byte enables start cleared so unwritten beats drain with no lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BEATS; i++) bmem[i] <= '0;
      full   <= 1'b0;
      base   <= '0;
      hi_idx <= '0;
      cmd    <= '0;
    end else begin
      if (release_i) begin
        for (int i = 0; i < BEATS; i++) bmem[i] <= '0;
        full <= 1'b0;
      end
      if (wr_en) begin
        bmem[wr_idx] <= wr_be;
        base         <= wr_base;
        hi_idx       <= wr_idx;
        cmd          <= wr_cmd;
      end
      if (set_full) full <= 1'b1;
    end
  end

  assign rd_data = dmem[rd_idx];
  assign rd_be   = bmem[rd_idx];

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    set_full |-> !full);
endmodule

// File: rtl/wfb_drain_ctrl.sv
module wfb_drain_ctrl #(
  parameter int IDX_W = 5,
  parameter int NB    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_cur,
  input  logic [IDX_W-1:0] hi_cur,
  input  logic             out_ready,
  output logic             dbank,
  output logic [IDX_W-1:0] rd_idx,
  output logic             out_valid,
  output logic             out_last,
  output logic [NB-1:0]    rel
);
  logic hs;

  assign out_valid = full_cur;
  assign out_last  = (rd_idx == hi_cur);
  assign hs        = out_valid && out_ready;

  always_comb begin
    rel = '0;
    rel[dbank] = hs && out_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbank  <= 1'b0;
      rd_idx <= '0;
    end else if (hs) begin
      if (out_last) begin
        rd_idx <= '0;
        dbank  <= ~dbank;
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rd_idx)));
endmodule

// File: rtl/wr_chunk_fwd.sv
module wr_chunk_fwd
  import wfb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CHUNK_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [3:0]        in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W/8-1:0] in_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [3:0]        out_cmd,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W/8-1:0] out_be,
  output logic              out_last
);
  localparam int BE_W  = DATA_W / 8;
  localparam int BSH   = $clog2(BE_W);
  localparam int BEATS = CHUNK_BYTES / BE_W;
  localparam int IDX_W = $clog2(BEATS);
  localparam int OFS_W = $clog2(CHUNK_BYTES);
  localparam int NB    = 2;

  logic                    wr_en, wr_bank, commit, dbank;
  logic [IDX_W-1:0]        wr_idx, rd_idx;
  logic [ADDR_W-OFS_W-1:0] wr_base;
  logic [3:0]              wr_cmd;
  logic [NB-1:0]           full, rel;

  logic [ADDR_W-OFS_W-1:0] base_b [NB];
  logic [IDX_W-1:0]        hi_b   [NB];
  logic [3:0]              cmd_b  [NB];
  logic [DATA_W-1:0]       data_b [NB];
  logic [BE_W-1:0]         be_b   [NB];

  wfb_fill_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BSH(BSH), .IDX_W(IDX_W), .NB(NB)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .in_cmd(in_cmd), .in_addr(in_addr), .full(full), .in_ready(in_ready), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_base(wr_base), .wr_cmd(wr_cmd), .commit(commit)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    wfb_chunk_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .OFS_W(OFS_W),
                     .BEATS(BEATS), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_bank == 1'(g))), .wr_idx(wr_idx), .wr_data(in_data), .wr_be(in_be),
      .wr_base(wr_base), .wr_cmd(wr_cmd), .set_full(commit && (wr_bank == 1'(g))),
      .release_i(rel[g]), .rd_idx(rd_idx), .full(full[g]), .base(base_b[g]),
      .hi_idx(hi_b[g]), .cmd(cmd_b[g]), .rd_data(data_b[g]), .rd_be(be_b[g])
    );
  end

  wfb_drain_ctrl #(.IDX_W(IDX_W), .NB(NB)) u_drain (
    .clk(clk), .rst_n(rst_n), .full_cur(full[dbank]), .hi_cur(hi_b[dbank]),
    .out_ready(out_ready), .dbank(dbank), .rd_idx(rd_idx), .out_valid(out_valid),
    .out_last(out_last), .rel(rel)
  );

  assign out_addr = {base_b[dbank], {OFS_W{1'b0}}};
  assign out_cmd  = wfb_xlate(cmd_b[dbank]);
  assign out_data = data_b[dbank];
  assign out_be   = be_b[dbank];

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && in_ready));

  a_r6_cmd_merged: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cmd != CMD_MWR_BLK));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)
                                   && $stable(out_be) && $stable(out_last)));
endmodule

// File: tb/wr_chunk_fwd_tb.sv
module wr_chunk_fwd_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        last;
    logic        dck;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [3:0]  in_cmd = '0;
  logic [31:0] in_addr = '0, in_data = '0;
  logic [3:0]  in_be = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_last;
  logic [31:0] out_addr, out_data;
  logic [3:0]  out_cmd, out_be;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 1;
  item_t exp_q[$];
  string tag_q[$];

  wr_chunk_fwd u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_cmd(in_cmd), .in_addr(in_addr),
    .in_data(in_data), .in_be(in_be), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_cmd(out_cmd), .out_data(out_data), .out_be(out_be),
    .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model from requirements, then drive the burst
  task automatic send_burst(input logic [31:0] a0, input int n, input logic [3:0] cmd, input string tag);
    logic [31:0] md [32];
    logic [3:0]  mb [32];
    bit          mw [32];
    logic [31:0] a;
    logic [4:0]  idx;
    for (int k = 0; k < 32; k++) mw[k] = 1'b0;
    for (int i = 0; i < n; i++) begin
      a = a0 + 32'(4 * i);
      idx = a[6:2];
      md[idx] = {a[15:0], 16'(i) ^ 16'h3C5A};
      mb[idx] = 4'(i * 7 + 3);
      mw[idx] = 1'b1;
      if (i == n - 1 || idx == 5'd31) begin
        for (int k = 0; k <= int'(idx); k++) begin
          exp_q.push_back('{addr: {a[31:7], 7'b0}, data: mw[k] ? md[k] : 32'h0,
                            be: mw[k] ? mb[k] : 4'h0, last: (k == int'(idx)), dck: mw[k]});
          tag_q.push_back(tag);
        end
        for (int k = 0; k < 32; k++) mw[k] = 1'b0;
      end
    end
    for (int i = 0; i < n; i++) begin
      a = a0 + 32'(4 * i);
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == 0);
      in_last  = (i == n - 1);
      in_cmd   = (i == 0) ? cmd : 4'h0;
      in_addr  = (i == 0) ? a0 : 32'hDEAD_0000 + 32'(i);   // R2: ignored after first
      in_data  = {a[15:0], 16'(i) ^ 16'h3C5A};
      in_be    = 4'(i * 7 + 3);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  // monitor / scoreboard
  logic        hold_p = 1'b0;
  logic [31:0] h_addr, h_data;
  logic [3:0]  h_be;
  logic        h_last;
  initial begin
    item_t e;
    string t;
    bit ok;
    forever begin
      @(negedge clk);
      out_ready = (rdy_mode == 0) ? 1'b0 : (rdy_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
      if (rst_n) begin
        if (hold_p) begin
          check(out_valid && out_addr == h_addr && out_data == h_data && out_be == h_be
                && out_last == h_last, "R8 held beat",
                {out_valid, out_addr, out_data, out_be, out_last},
                {1'b1, h_addr, h_data, h_be, h_last});
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected beat", {out_addr, out_data}, '0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            ok = out_addr == e.addr && out_be == e.be && out_last == e.last
                 && out_cmd == 4'b0111 && (!e.dck || out_data == e.data);
            check(ok, t, {out_addr, out_data, out_be, out_last, out_cmd},
                         {e.addr, e.data, e.be, e.last, 4'b0111});
          end
        end
        hold_p = out_valid && !out_ready;
        h_addr = out_addr; h_data = out_data; h_be = out_be; h_last = out_last;
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 80'(out_valid), 80'(0));
    check(in_ready == 1'b1, "R1 in_ready after reset", 80'(in_ready), 80'(1));

    send_burst(32'h0000_1000, 32, 4'b0111, "R3 aligned full chunk R2");
    send_burst(32'h0000_2008, 5, 4'b1111, "R4 R5 R6 short block burst");
    send_burst(32'h0000_30F0, 40, 4'b0111, "R9 multi-region split");
    send_burst(32'h0000_5040, 16, 4'b1111, "R4 R3 end on boundary");
    repeat (80) @(negedge clk);

    @(posedge clk); rdy_mode = 0;
    send_burst(32'h0000_6000, 64, 4'b0111, "R7 two chunks queued");
    @(negedge clk);
    check(in_ready == 1'b0, "R7 stall with both chunks pending", 80'(in_ready), 80'(0));
    check(out_valid == 1'b1, "R7 output offered during stall", 80'(out_valid), 80'(1));
    @(posedge clk); rdy_mode = 2;
    send_burst(32'h0000_7014, 100, 4'b1111, "R7 R8 overlap under back-pressure");

    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
    check(exp_q.size() == 0, "R9 all beats delivered", 80'(exp_q.size()), 80'(0));
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R4 idle after drain", 80'(out_valid), 80'(0));
    summary();
  end
endmodule